// File: doc/BRIEF.md
# Standby Bus Wake-Up Qualifier

This block sits behind the low-power bus comparator of a transceiver. It turns the raw, already sampled bus-dominant bit into a clean wake-request level while the device is in its low-power state. Both bus states have to hold for a minimum number of clock cycles before the output follows them, so the filter does not latch: a dominant stretch that is long enough asserts the request, and a recessive stretch that is long enough withdraws it again. Shorter pulses in either direction are ignored.

A second, much longer counter watches how long the raw bus stays dominant. If the bus looks clamped dominant past this limit, the block drops the wake request and raises a stuck-bus status flag. The request can only return after the bus has been qualified recessive and then qualified dominant again. When the low-power state is left, every counter clears and the output goes idle. The parameter `FILT_CYC` sets the filter length in clock cycles and `TMO_CYC` sets the stuck-bus limit. `TMO_CYC` must be larger than `FILT_CYC`.

Top module: `wkf_standby_wake`

## Requirements
- R1: While `rst` is high, or on any clock edge where `stby_en` is low, the block clears all its counters. `wake_n` reads 1 and `stuck_flag` reads 0 after that edge.
- R2: With `stby_en` high, `wake_n` falls to 0 one clock after the edge that samples the `FILT_CYC`-th consecutive dominant value (`bus_dom`=1), provided no stuck condition is active.
- R3: The filter does not latch. Once the qualified state is dominant, `wake_n` returns to 1 one clock after the edge that samples the `FILT_CYC`-th consecutive recessive value (`bus_dom`=0).
- R4: A run of fewer than `FILT_CYC` samples that differ from the qualified state leaves `wake_n` unchanged. The next sample that agrees with the qualified state restarts the persistence count from zero.
- R5: With `stby_en` high, the edge that samples the `TMO_CYC`-th consecutive raw dominant value sets `stuck_flag`. `wake_n` is 1 from the following clock on, for as long as the flag stays set.
- R6: A single raw recessive sample restarts the stuck-bus count. This holds even when the sample is too short to change the qualified state.
- R7: After a stuck condition, `stuck_flag` clears one clock after the qualified state becomes recessive. `wake_n` falls again only after a new run of `FILT_CYC` dominant samples.
- R8: With `STUCK_FLAG_EN`=0, `stuck_flag` is held at 0. The timeout still acts on `wake_n` exactly as in R5 to R7.
- R9: On re-entering standby, the qualified state starts recessive. A bus already dominant needs a full `FILT_CYC` run before `wake_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| stby_en | input | 1 | High while the device is in the low-power state |
| bus_dom | input | 1 | Sampled comparator output, 1 = bus dominant |
| wake_n | output | 1 | Registered wake request, 0 = request detected |
| stuck_flag | output | 1 | Registered stuck-dominant status |

## Verification
The bench targets runs exactly one sample short of the filter length in both directions. A filter that counts one too few would flip the output there, and a filter that fails to restart on a glitch would flip it on a later short run. The bench also drives dominant stretches of exactly the timeout length, and stretches broken by a single recessive sample just before it. A timer that ignores raw recessive samples would then raise the flag falsely, and an off-by-one limit would raise it one cycle early or late. The bench checks recovery after a timeout and standby exits with the bus held dominant. A design that re-arms without a qualified recessive phase, or keeps stale filter state across standby, would assert the request too soon.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  // width of a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

  localparam logic WAKE_IDLE = 1'b1;  // wake_n level with no request
  localparam logic LVL_REC   = 1'b0;
  localparam logic LVL_DOM   = 1'b1;
endpackage

// File: rtl/wkf_persist_filter.sv
// Symmetric persistence filter: q follows smp only after smp has differed
// from q for LEN consecutive samples.
module wkf_persist_filter #(
  parameter int LEN = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic smp,
  output logic q
);
  import wkf_pkg::*;
  localparam int CW = cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run_q <= '0;
      lvl_q <= LVL_REC;
    end else if (smp != lvl_q) begin
      if (run_q == LAST) begin
        lvl_q <= smp;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

  assign q = lvl_q;
endmodule

// File: rtl/wkf_dom_watchdog.sv
// Counts consecutive raw dominant samples; sets stuck after LIMIT of them.
// Stuck is released once the qualified level reads recessive.
module wkf_dom_watchdog #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic dom,
  input  logic filt_lvl,
  output logic stuck
);
  import wkf_pkg::*;
  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] len_q;
  logic          stuck_q;
  logic          hit;

  assign hit = dom && (len_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      len_q <= '0;
    end else if (!dom) begin
      len_q <= '0;
    end else if (len_q != LAST) begin
      len_q <= len_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stuck_q <= 1'b0;
    end else if (hit) begin
      stuck_q <= 1'b1;
    end else if (filt_lvl == LVL_REC) begin
      stuck_q <= 1'b0;
    end
  end

  assign stuck = stuck_q;
endmodule

// File: rtl/wkf_out_stage.sv
// Registered active-low request output.
module wkf_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic filt_lvl,
  input  logic stuck,
  output logic wake_n
);
  import wkf_pkg::*;
  logic req;
  logic wake_q;

  assign req = active && (filt_lvl == LVL_DOM) && !stuck;

  always_ff @(posedge clk) begin
    if (rst) wake_q <= WAKE_IDLE;
    else     wake_q <= !req;
  end

  assign wake_n = wake_q;
endmodule

// File: rtl/wkf_standby_wake.sv
module wkf_standby_wake #(
  parameter int FILT_CYC      = 375,
  parameter int TMO_CYC       = 500000,
  parameter bit STUCK_FLAG_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_en,
  input  logic bus_dom,
  output logic wake_n,
  output logic stuck_flag
);
  logic idle_clr;
  logic filt_lvl;
  logic stuck;

  assign idle_clr = !stby_en;

  wkf_persist_filter #(.LEN(FILT_CYC)) u_filt (
    .clk (clk),
    .rst (rst),
    .clr (idle_clr),
    .smp (bus_dom),
    .q   (filt_lvl)
  );

  wkf_dom_watchdog #(.LIMIT(TMO_CYC)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .clr      (idle_clr),
    .dom      (bus_dom),
    .filt_lvl (filt_lvl),
    .stuck    (stuck)
  );

  wkf_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .active   (stby_en),
    .filt_lvl (filt_lvl),
    .stuck    (stuck),
    .wake_n   (wake_n)
  );

  generate
    if (STUCK_FLAG_EN) begin : g_flag
      assign stuck_flag = stuck;
    end else begin : g_noflag
      assign stuck_flag = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wkf_standby_wake_chk.sv
module wkf_standby_wake_chk #(
  parameter int FILT_CYC      = 375,
  parameter int TMO_CYC       = 500000,
  parameter bit STUCK_FLAG_EN = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic stby_en,
  input logic bus_dom,
  input logic wake_n,
  input logic stuck_flag
);
  localparam int RW = $clog2(TMO_CYC + 2) + 1;
  localparam logic [RW-1:0] RMAX = RW'(TMO_CYC + 1);

  logic [RW-1:0] dom_run;
  always_ff @(posedge clk) begin
    if (rst || !stby_en || !bus_dom) dom_run <= '0;
    else if (dom_run != RMAX)        dom_run <= dom_run + 1'b1;
  end

  AST_IDLE_WAKE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !stby_en |=> wake_n); // R1
  AST_IDLE_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
    !stby_en |=> !stuck_flag); // R1
  AST_FALL_NEEDS_DOM: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_n) |-> ($past(bus_dom, 2) && $past(stby_en))); // R2
  AST_LONG_DOM_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (dom_run > RW'(TMO_CYC)) |-> wake_n); // R5

  generate
    if (STUCK_FLAG_EN) begin : g_flag_chk
      AST_STUCK_HIDES_REQ: assert property (@(posedge clk) disable iff (rst)
        stuck_flag |=> wake_n); // R5
      AST_STUCK_NEEDS_DOM: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck_flag) |-> ($past(bus_dom) && $past(stby_en))); // R6
      AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_n) |-> (!$past(stby_en) || $past(stuck_flag) || !$past(bus_dom, 2))); // R3
    end else begin : g_noflag_chk
      AST_FLAG_TIED_LOW: assert property (@(posedge clk) disable iff (rst)
        !stuck_flag); // R8
    end
  endgenerate
endmodule

bind wkf_standby_wake wkf_standby_wake_chk #(
  .FILT_CYC(FILT_CYC), .TMO_CYC(TMO_CYC), .STUCK_FLAG_EN(STUCK_FLAG_EN)
) u_chk (
  .clk(clk), .rst(rst), .stby_en(stby_en), .bus_dom(bus_dom),
  .wake_n(wake_n), .stuck_flag(stuck_flag)
);

// File: tb/wkf_standby_wake_test.sv
module wkf_standby_wake_test;
  localparam int F = 6;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby_en = 1'b0;
  logic bus_dom = 1'b0;
  logic wake_n, stuck_flag, nf_wake_n, nf_stuck_flag;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  // reference state
  logic m_filt, m_stuck, m_wake;
  int   m_run, m_dlen;

  always #2 clk = ~clk;

  wkf_standby_wake #(.FILT_CYC(F), .TMO_CYC(T), .STUCK_FLAG_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .stby_en(stby_en), .bus_dom(bus_dom),
    .wake_n(wake_n), .stuck_flag(stuck_flag));

  wkf_standby_wake #(.FILT_CYC(F), .TMO_CYC(T), .STUCK_FLAG_EN(1'b0)) uut_nf (
    .clk(clk), .rst(rst), .stby_en(stby_en), .bus_dom(bus_dom),
    .wake_n(nf_wake_n), .stuck_flag(nf_stuck_flag));

  function automatic logic exp_wake(input logic act, input logic filt, input logic stk);
    return !(act && filt && !stk);
  endfunction

  task automatic model_reset();
    m_filt = 1'b0; m_stuck = 1'b0; m_wake = 1'b1; m_run = 0; m_dlen = 0;
  endtask

  task automatic model_step(input logic r, input logic s, input logic d);
    logic nf, ns;
    int nr, nd;
    if (r) begin model_reset(); return; end
    m_wake = exp_wake(s, m_filt, m_stuck);
    if (!s) begin
      m_filt = 1'b0; m_stuck = 1'b0; m_run = 0; m_dlen = 0;
      return;
    end
    // stuck-bus timer on raw samples (R5, R6, R7)
    ns = m_stuck;
    if (d && m_dlen + 1 >= T) ns = 1'b1;
    else if (!m_filt)        ns = 1'b0;
    nd = d ? ((m_dlen + 1 >= T) ? m_dlen : m_dlen + 1) : 0;
    // persistence (R2, R3, R4)
    nf = m_filt; nr = 0;
    if (d != m_filt) begin
      if (m_run + 1 >= F) nf = d;
      else nr = m_run + 1;
    end
    m_filt = nf; m_run = nr; m_stuck = ns; m_dlen = nd;
  endtask

  task automatic check1(input string rq, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t actual=%b expected=%b", rq, $time, act, exp);
    end
  endtask

  // called at a falling edge: drive, clock, compare at next falling edge
  task automatic cyc(input logic s, input logic d);
    stby_en = s; bus_dom = d;
    @(posedge clk);
    model_step(rst, s, d);
    @(negedge clk);
    check1({tag, " wake_n"}, wake_n, m_wake);
    check1({tag, " stuck_flag"}, stuck_flag, m_stuck);
    check1("R8 flag tied", nf_stuck_flag, 1'b0);
    check1("R8 wake match", nf_wake_n, m_wake);
  endtask

  task automatic run(input logic s, input logic d, input int n);
    for (int i = 0; i < n; i++) cyc(s, d);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    @(negedge clk);
    tag = "R1";
    run(1'b1, 1'b1, 3);           // reset dominates inputs
    rst = 1'b0;
    run(1'b0, 1'b1, 4);           // idle: no request while not in standby
    // R4: dominant one short of filter, then recessive
    tag = "R4";
    run(1'b1, 1'b1, F - 1);
    run(1'b1, 1'b0, 2);
    run(1'b1, 1'b1, F - 1);
    run(1'b1, 1'b0, 1);
    // R2: full qualified dominant
    tag = "R2";
    run(1'b1, 1'b1, F + 2);
    // R4: recessive glitch short of filter while request active
    tag = "R4";
    run(1'b1, 1'b0, F - 1);
    run(1'b1, 1'b1, 3);
    // R3: qualified recessive withdraws request
    tag = "R3";
    run(1'b1, 1'b0, F + 2);
    // R5: clamped dominant
    tag = "R5";
    run(1'b1, 1'b1, T + 6);
    // R7: recovery needs qualified recessive then dominant
    tag = "R7";
    run(1'b1, 1'b0, F - 1);
    run(1'b1, 1'b1, 3);
    run(1'b1, 1'b0, F + 1);
    run(1'b1, 1'b1, F + 2);
    // R6: single recessive sample restarts the timer
    tag = "R6";
    run(1'b1, 1'b1, T - 2 - F);
    run(1'b1, 1'b0, 1);
    run(1'b1, 1'b1, T - 1);
    run(1'b1, 1'b0, 1);
    run(1'b1, 1'b1, T);           // exactly the limit after a break
    // R1 / R9: leave standby with request active, re-enter dominant
    tag = "R9";
    run(1'b1, 1'b0, F + 1);
    run(1'b1, 1'b1, F + 1);
    run(1'b0, 1'b1, 2);
    run(1'b1, 1'b1, F + 2);
    // R5 then exit standby while stuck
    tag = "R1";
    run(1'b1, 1'b1, T + 2);
    run(1'b0, 1'b1, 1);
    run(1'b1, 1'b1, F + 1);
    // random segments
    tag = "R2 R3 R4 R5 R6 R7 random";
    for (int seg = 0; seg < 400; seg++) begin
      int len;
      logic lvl, sb;
      lvl = logic'(seg[0]);
      sb = ($urandom % 25) != 0;
      case ($urandom % 8)
        0: len = T - 1 + int'($urandom % 4);
        1: len = F - 1 + int'($urandom % 3);
        default: len = 1 + int'($urandom % (2 * F));
      endcase
      if (len > T && !lvl) len = F;
      run(sb, lvl, len);
    end
    report();
  end
endmodule